// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter with Graceful Pause

This block is the send half of a two-channel serial audio port. A DMA engine fills an eight-entry sample queue through a request/acknowledge handshake. A serializer drains the queue one sample per slot. Samples alternate left and right, and each slot is sixteen bits long. Each bit period is marked by a one-cycle strobe from an external divider. The block produces the bit clock, the word-select line and the data line. The data line changes with the falling edge of the bit clock.

A small control register holds four read/write bits: DMA enable, DMA hold, channel hold and word-select polarity. The read port also returns status: queue empty, queue full and the channel now on the wire. The two hold bits stop their side at a safe point. DMA hold lets an outstanding request finish first. Channel hold lets the right sample of the current stereo pair finish first. Clearing DMA enable instead withdraws the request on the same clock edge.

Top module: `i2s_tx_path`

## Requirements
- R1: After reset the queue is empty and not full. `dma_req` is 0, `i2s_sd` is 0 and `i2s_ws` is 1. The channel status reads 1 (right) and all four control bits read 0.
- R2: `ctl_rdata[4]` reads 1 exactly when the queue holds no samples. `ctl_rdata[5]` reads 1 exactly when it holds 8.
- R3: When no transfer is outstanding, `dma_req` is 1 only while DMA enable (bit 0) is 1, DMA hold (bit 1) is 0 and the queue has room. Each cycle with `dma_req` and `dma_ack` both high writes one `dma_data` sample. An acknowledge while `dma_req` is low writes nothing.
- R4: If DMA hold is set while `dma_req` is high, the request stays high until it is acknowledged and then drops. Clearing DMA hold brings the request back.
- R5: Writing 0 to DMA enable drops `dma_req` at the same edge that updates the register, even while a request is unacknowledged.
- R6: A run starts on the first strobe after a stop. That strobe moves word-select to the left level and loads the next sample. Each later slot is 16 strobes. Word-select changes one strobe before the slot's MSB appears. Bits follow MSB first, and samples leave in queue order, alternating left and right.
- R7: If the queue is empty when a sample is due, that slot carries zeros and the queue is not read.
- R8: When channel hold (bit 2) is set, the serializer continues until the LSB of a right slot has gone out, and only then stops. While stopped, `i2s_sd` is 0, word-select keeps its level and no sample is taken from the queue.
- R9: With polarity (bit 3) at 0, `i2s_ws` is 0 for left and 1 for right. With polarity at 1 the levels swap. `ctl_rdata[6]` is 1 for the right channel whatever the polarity.
- R10: Bits [3:0] of `ctl_rdata` read back the last written control value. Writes to bits [7:4] have no effect, and `ctl_rdata[7]` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Write data: [0] DMA enable, [1] DMA hold, [2] channel hold, [3] polarity |
| ctl_rdata | output | 8 | Control bits [3:0], empty [4], full [5], right channel [6], 0 [7] |
| dma_req | output | 1 | Request for one sample |
| dma_ack | input | 1 | Acknowledge; the sample is on `dma_data` this cycle |
| dma_data | input | 16 | Sample from the DMA engine |
| bit_tick | input | 1 | One-cycle strobe per serial bit period |
| i2s_bclk | output | 1 | Bit clock, low for the cycle after each strobe |
| i2s_ws | output | 1 | Word select |
| i2s_sd | output | 1 | Serial data |

## Verification
A queue pointer or count that goes wrong appears at the empty and full status bits as soon as the next push or pop. It also shows on the wire as a repeated, skipped or zero slot within 16 strobes. A slot flag or bit counter off by one shifts word-select against the data by whole strobes, or makes a hold stop after a left slot. Either fault is visible within one frame of 32 strobes. An error in the request logic shows in one cycle: the request outlives a cleared enable, drops while a transfer is still outstanding, or rises when the queue is full.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
    typedef struct packed {
        logic ws_invert;
        logic ch_hold;
        logic dma_hold;
        logic dma_en;
    } tx_ctrl_t;

    localparam int CTRL_W = 4;
endpackage

// File: rtl/i2s_tx_fifo.sv
module i2s_tx_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);
    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [CW-1:0] count;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [W-1:0] mem_q [DEPTH];

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.wr_ptr = (st_q.wr_ptr == AW'(DEPTH - 1)) ? '0 : st_q.wr_ptr + AW'(1);
        end
        if (pop) begin
            st_d.rd_ptr = (st_q.rd_ptr == AW'(DEPTH - 1)) ? '0 : st_q.rd_ptr + AW'(1);
        end
        st_d.count = st_q.count + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            mem_q[st_q.wr_ptr] <= wdata;
        end
    end

    assign rdata = mem_q[st_q.rd_ptr];
    assign count = st_q.count;
    assign empty = (st_q.count == '0);
    assign full  = (st_q.count == CW'(DEPTH));

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (st_q.count != CW'(DEPTH)));

    // R7
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (st_q.count != '0));
endmodule

// File: rtl/i2s_tx_dma_gate.sv
module i2s_tx_dma_gate #(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_nx,
    input  logic          hold_nx,
    input  logic          ack,
    input  logic          pop,
    input  logic [CW-1:0] count,
    output logic          req,
    output logic          push
);
    typedef struct packed {
        logic req;
    } gate_st_t;

    gate_st_t st_d, st_q;
    logic [CW:0] count_nx;

    always_comb begin
        push     = st_q.req & ack;
        count_nx = {1'b0, count} + (CW + 1)'(push) - (CW + 1)'(pop);
        st_d     = st_q;
        if (!en_nx) begin
            st_d.req = 1'b0;
        end else if (st_q.req && !ack) begin
            st_d.req = 1'b1;
        end else begin
            st_d.req = !hold_nx && (count_nx < (CW + 1)'(DEPTH));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req = st_q.req;

    // R3
    req_needs_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.req |-> (count != CW'(DEPTH)));
endmodule

// File: rtl/i2s_tx_shifter.sv
module i2s_tx_shifter #(
    parameter int W      = 16,
    localparam int CNT_W = $clog2(W)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         hold,
    input  logic         fifo_empty,
    input  logic [W-1:0] fifo_rdata,
    output logic         pop,
    output logic         sd,
    output logic         slot_right,
    output logic         bclk
);
    typedef struct packed {
        logic             running;
        logic             slot;
        logic [CNT_W-1:0] cnt;
        logic [W-1:0]     sr;
        logic             sd;
        logic             bclk;
    } sh_st_t;

    sh_st_t st_d, st_q;
    logic [W-1:0] load;

    always_comb begin
        st_d      = st_q;
        pop       = 1'b0;
        load      = fifo_empty ? '0 : fifo_rdata;
        st_d.bclk = !tick;
        if (tick) begin
            if (!st_q.running) begin
                st_d.sd = 1'b0;
                if (!hold) begin
                    st_d.running = 1'b1;
                    st_d.slot    = 1'b0;
                    st_d.cnt     = '0;
                    st_d.sr      = load;
                    pop          = !fifo_empty;
                end
            end else begin
                st_d.sd  = st_q.sr[W-1];
                st_d.sr  = st_q.sr << 1;
                st_d.cnt = st_q.cnt + CNT_W'(1);
                if (st_q.cnt == CNT_W'(W - 1)) begin
                    st_d.cnt = '0;
                    if (st_q.slot && hold) begin
                        st_d.running = 1'b0;
                    end else begin
                        st_d.slot = !st_q.slot;
                        st_d.sr   = load;
                        pop       = !fifo_empty;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.slot    <= 1'b1;
            st_q.bclk    <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sd         = st_q.sd;
    assign slot_right = st_q.slot;
    assign bclk       = st_q.bclk;

    // R8
    pair_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.running) |-> (st_q.slot && $past(st_q.cnt) == CNT_W'(W - 1)));

    // R8
    pause_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.running && tick) |=> !st_q.sd);

    // R8
    pause_ws_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.running && $past(!st_q.running)) |-> $stable(st_q.slot));
endmodule

// File: rtl/i2s_tx_path.sv
module i2s_tx_path
    import i2s_tx_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int DEPTH    = 8,
    localparam int CW      = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctl_we,
    input  logic [7:0]          ctl_wdata,
    output logic [7:0]          ctl_rdata,
    output logic                dma_req,
    input  logic                dma_ack,
    input  logic [SAMPLE_W-1:0] dma_data,
    input  logic                bit_tick,
    output logic                i2s_bclk,
    output logic                i2s_ws,
    output logic                i2s_sd
);
    tx_ctrl_t ctrl_d, ctrl_q;

    logic                push, pop;
    logic [SAMPLE_W-1:0] fifo_rdata;
    logic [CW-1:0]       fifo_count;
    logic                fifo_empty, fifo_full;
    logic                slot_right;

    always_comb begin
        ctrl_d = ctrl_q;
        if (ctl_we) begin
            ctrl_d = tx_ctrl_t'(ctl_wdata[CTRL_W-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    i2s_tx_fifo #(.W(SAMPLE_W), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .wdata (dma_data),
        .pop   (pop),
        .rdata (fifo_rdata),
        .count (fifo_count),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    i2s_tx_dma_gate #(.DEPTH(DEPTH)) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_nx   (ctrl_d.dma_en),
        .hold_nx (ctrl_d.dma_hold),
        .ack     (dma_ack),
        .pop     (pop),
        .count   (fifo_count),
        .req     (dma_req),
        .push    (push)
    );

    i2s_tx_shifter #(.W(SAMPLE_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (bit_tick),
        .hold       (ctrl_q.ch_hold),
        .fifo_empty (fifo_empty),
        .fifo_rdata (fifo_rdata),
        .pop        (pop),
        .sd         (i2s_sd),
        .slot_right (slot_right),
        .bclk       (i2s_bclk)
    );

    assign i2s_ws    = slot_right ^ ctrl_q.ws_invert;
    assign ctl_rdata = {1'b0, slot_right, fifo_full, fifo_empty, ctrl_q};

    // R5
    abort_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl_q.dma_en) |-> !dma_req);

    // R4
    inflight_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && !dma_ack && !(ctl_we && !ctl_wdata[0])) |=> dma_req);

    // R3
    idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.dma_en) |-> !dma_req);
endmodule

// File: tb/i2s_tx_path_bench.sv
module i2s_tx_path_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0;
    logic [7:0]  ctl_wdata = '0;
    logic [7:0]  ctl_rdata;
    logic        dma_req;
    logic        dma_ack = 1'b0;
    logic [15:0] dma_data = '0;
    logic        bit_tick = 1'b0;
    logic        i2s_bclk, i2s_ws, i2s_sd;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic ws_log [256];
    logic sd_log [256];
    logic ch_log [256];
    int   nt = 0;

    always #10 clk = !clk;

    i2s_tx_path u_i2s_tx_path (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .dma_req(dma_req), .dma_ack(dma_ack),
        .dma_data(dma_data), .bit_tick(bit_tick), .i2s_bclk(i2s_bclk),
        .i2s_ws(i2s_ws), .i2s_sd(i2s_sd)
    );

    function automatic logic [15:0] smp(input int i);
        return 16'(32'hA5C3 + i * 32'h1F29);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk);
        ctl_we = 1'b1;
        ctl_wdata = v;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic ack_one(input logic [15:0] d);
        while (!dma_req) @(negedge clk);
        dma_ack = 1'b1;
        dma_data = d;
        @(negedge clk);
        dma_ack = 1'b0;
    endtask

    task automatic raw_ack();
        @(negedge clk);
        dma_ack = 1'b1;
        dma_data = 16'hDEAD;
        @(negedge clk);
        dma_ack = 1'b0;
    endtask

    task automatic do_tick();
        @(negedge clk);
        bit_tick = 1'b1;
        @(negedge clk);
        bit_tick = 1'b0;
        ws_log[nt] = i2s_ws;
        sd_log[nt] = i2s_sd;
        ch_log[nt] = ctl_rdata[6];
        nt++;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic word_chk(input int t0, input int w, input logic [15:0] exp,
                            input logic lvl, input string req);
        logic [15:0] got;
        for (int j = 0; j < 16; j++) begin
            got[15 - j] = sd_log[t0 + 16 * w + 1 + j];
        end
        chk(got == exp, req, got, exp);
        chk(ws_log[t0 + 16 * w] == lvl && ws_log[t0 + 16 * w + 15] == lvl,
            "R6 ws level over slot", ws_log[t0 + 16 * w], lvl);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(ctl_rdata == 8'h50, "R1 status after reset", ctl_rdata, 8'h50);
        chk(!dma_req && !i2s_sd && i2s_ws, "R1 lines after reset",
            {dma_req, i2s_sd, i2s_ws}, 3'b001);

        // R10 control readback and read-only status
        wr(8'hFE);
        chk(ctl_rdata == 8'h5E, "R10 readback with upper ones", ctl_rdata, 8'h5E);
        wr(8'hF0);
        chk(ctl_rdata == 8'h50, "R10 upper bits ignored", ctl_rdata, 8'h50);
        chk(!dma_req, "R3 no request with hold", dma_req, 0);

        // R3 acknowledge without request writes nothing
        raw_ack();
        chk(ctl_rdata[4] == 1'b1, "R3 stray ack ignored", ctl_rdata[4], 1);

        // R3 / R4 DMA fill with hold during an outstanding request
        wr(8'h01);
        chk(dma_req, "R3 request on enable", dma_req, 1);
        ack_one(smp(0));
        chk(ctl_rdata[4] == 1'b0, "R2 not empty after push", ctl_rdata[4], 0);
        ack_one(smp(1));
        chk(dma_req, "R3 request while room", dma_req, 1);
        wr(8'h03);
        chk(dma_req, "R4 outstanding request kept", dma_req, 1);
        repeat (5) @(negedge clk);
        chk(dma_req, "R4 outstanding request still kept", dma_req, 1);
        ack_one(smp(2));
        chk(!dma_req, "R4 request drops after ack", dma_req, 0);
        repeat (5) @(negedge clk);
        chk(!dma_req, "R4 request stays off while held", dma_req, 0);
        wr(8'h01);
        chk(dma_req, "R4 request resumes", dma_req, 1);
        for (int i = 3; i < 7; i++) ack_one(smp(i));
        chk(ctl_rdata[5] == 1'b0, "R2 not full at seven", ctl_rdata[5], 0);
        ack_one(smp(7));
        chk(ctl_rdata[5] == 1'b1, "R2 full at eight", ctl_rdata[5], 1);
        chk(!dma_req, "R3 no request when full", dma_req, 0);
        wr(8'h00);
        raw_ack();
        chk(ctl_rdata[5] == 1'b1, "R3 stray ack while full", ctl_rdata[5], 1);

        // R6 / R8 serialize, hold set during a left slot
        for (int t = 0; t <= 40; t++) do_tick();
        wr(8'h04);
        while (nt <= 80) do_tick();
        for (int w = 0; w < 4; w++) word_chk(0, w, smp(w), 1'(w % 2), "R6 sample data");
        for (int t = 65; t <= 80; t++) begin
            chk(sd_log[t] == 1'b0 && ws_log[t] == 1'b1 && ch_log[t] == 1'b1,
                "R8 paused lines", {sd_log[t], ws_log[t], ch_log[t]}, 3'b011);
        end
        chk(ws_log[64] == 1'b1, "R8 no ws change at stop", ws_log[64], 1);

        // R9 inverted polarity, R8 no pops while paused, R7 zero fill
        wr(8'h08);
        while (nt <= 177) do_tick();
        for (int w = 0; w < 4; w++) word_chk(81, w, smp(w + 4), 1'((w % 2) ^ 1), "R8 resume data");
        word_chk(81, 4, 16'h0000, 1'b1, "R7 zero slot left");
        word_chk(81, 5, 16'h0000, 1'b0, "R7 zero slot right");
        chk(ch_log[81 + 5] == 1'b0 && ws_log[81 + 5] == 1'b1, "R9 channel bit left",
            {ch_log[86], ws_log[86]}, 2'b01);
        chk(ch_log[81 + 20] == 1'b1 && ws_log[81 + 20] == 1'b0, "R9 channel bit right",
            {ch_log[101], ws_log[101]}, 2'b10);
        chk(ctl_rdata[4] == 1'b1, "R2 empty after drain", ctl_rdata[4], 1);

        // R5 abort of an unacknowledged request
        wr(8'h09);
        chk(dma_req, "R5 request up before abort", dma_req, 1);
        wr(8'h08);
        chk(!dma_req, "R5 request dropped at once", dma_req, 0);
        chk(ctl_rdata[4] == 1'b1, "R5 nothing written", ctl_rdata[4], 1);

        finish_run();
    end
endmodule